// File: doc/BRIEF.md
# Three-Phase Commutation and Brake Logic

This block converts three Hall logic bits into gate enables for a three-phase bridge, with one high-side and one low-side enable per phase. A Hall bit is 1 when its sensor's positive input exceeds its negative input. Each valid Hall code selects a source phase and a sink phase. The third phase floats. A direction input swaps source and sink, which reverses the rotation.

A mode state machine follows the active-low start input and the active-low brake select. It has three states: MD_RUN (driving), MD_COAST (stopped, all FETs off) and MD_BRAKE (stopped, all low sides on). Its transitions are as follows. Start going low moves any state to MD_RUN. Start going high leaves MD_RUN for MD_COAST or MD_BRAKE, depending on brake select. While stopped, a change of brake select moves between MD_COAST and MD_BRAKE.

In MD_RUN the PWM bit chops the high side of the source phase. While PWM is 0, that phase's low side conducts instead, so the winding current does not flow through the body diode. Each phase has its own gate state machine with the states PH_OFF, PH_HIGH, PH_LOW and PH_DEAD. Its transitions are:
- PH_OFF goes to PH_HIGH or PH_LOW on request.
- PH_HIGH and PH_LOW go to PH_DEAD when their request drops.
- PH_DEAD holds for DEAD_CYCLES clocks and then enters whatever state is requested at that moment.

A protection input blanks every high-side enable directly at the outputs. The Hall bias enable is on only in MD_RUN.

Top module: `bldc_commutator`

## Requirements
- R1: With direction = 0 in MD_RUN and PWM = 1, the Hall code {hall[2],hall[1],hall[0]} selects the phases as follows (bit i belongs to phase i of the gate vectors). The first phase listed is the source, with its high side on. The second is the sink, with its low side on.
  - 001: phases 0, 1
  - 011: phases 0, 2
  - 010: phases 1, 2
  - 110: phases 1, 0
  - 100: phases 2, 0
  - 101: phases 2, 1
- R2: With direction = 1, every valid code swaps the source and sink phases of R1.
- R3: Hall codes 000 and 111 turn all six gate enables off.
- R4: start_n = 0 selects MD_RUN, and the Hall bias enable is 1 exactly in MD_RUN. start_n = 1 stops the drive, and the bias enable is 0.
- R5: When stopped with brake_sel_n = 1, all six gate enables are off (free run).
- R6: When stopped with brake_sel_n = 0, all three low-side enables are on and all high sides are off (short-circuit brake).
- R7: In MD_RUN with PWM = 0, the source phase's high side is off and its low side is on, together with the sink's low side.
- R8: A phase never has both enables on. Between one side turning off and the other side turning on, both sides stay off for exactly DEAD_CYCLES clocks.
- R9: hs_kill = 1 forces all high-side enables to 0 in the same cycle. The low-side enables are unchanged.
- R10: During reset all gate enables and the bias enable are 0, and the mode is MD_COAST.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hall | input | 3 | Hall logic bits, bit i for phase i |
| dir_rev | input | 1 | 1 = reverse commutation |
| start_n | input | 1 | 0 = run, 1 = stop |
| brake_sel_n | input | 1 | When stopped: 0 = short brake, 1 = free run |
| pwm_on | input | 1 | PWM chop bit, 1 = high side conducting |
| hs_kill | input | 1 | Protection: blanks all high sides |
| gate_hi | output | 3 | High-side enables, bit i for phase i |
| gate_lo | output | 3 | Low-side enables, bit i for phase i |
| hall_bias | output | 1 | Hall bias enable |

## Verification
The checks take all inputs as synchronous to clk. They also assume DEAD_CYCLES is at least 1. The dead-gap checks assume the high-side enable only rises from a phase that was already in PH_HIGH or had just left PH_DEAD, so unmasking by hs_kill never counts as a fresh turn-on. The stimulus changes inputs only on falling edges. It then holds every setting for DEAD_CYCLES plus four clocks before comparing, so each comparison sees the state reached after the mode register, the dead-time wait and the phase state have all settled. The dead-gap measurements toggle only the PWM bit, one step at a time from a settled state.

// File: rtl/bldc_pkg.sv
package bldc_pkg;

    localparam int NUM_PH = 3;

    typedef enum logic [1:0] {
        MD_COAST = 2'd0,
        MD_BRAKE = 2'd1,
        MD_RUN   = 2'd2
    } drive_mode_e;

    typedef enum logic [1:0] {
        PH_OFF  = 2'd0,
        PH_HIGH = 2'd1,
        PH_LOW  = 2'd2,
        PH_DEAD = 2'd3
    } phase_st_e;

endpackage

// File: rtl/drive_mode_fsm.sv
module drive_mode_fsm
    import bldc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_n,
    input  logic        brake_sel_n,
    output drive_mode_e mode
);

    drive_mode_e cur_q;
    drive_mode_e nxt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= MD_COAST;
        else        cur_q <= nxt;
    end

    // transitions
    always_comb begin
        nxt = cur_q;
        unique case (cur_q)
            MD_RUN: begin
                if (start_n) nxt = brake_sel_n ? MD_COAST : MD_BRAKE;
            end
            MD_COAST: begin
                if (!start_n)         nxt = MD_RUN;
                else if (!brake_sel_n) nxt = MD_BRAKE;
            end
            MD_BRAKE: begin
                if (!start_n)        nxt = MD_RUN;
                else if (brake_sel_n) nxt = MD_COAST;
            end
            default: nxt = MD_COAST;
        endcase
    end

    // outputs
    always_comb mode = cur_q;

endmodule

// File: rtl/hall_commutator.sv
module hall_commutator
    import bldc_pkg::*;
(
    input  drive_mode_e        mode,
    input  logic [NUM_PH-1:0]  hall,
    input  logic               dir_rev,
    input  logic               pwm_on,
    output logic [NUM_PH-1:0]  want_hi,
    output logic [NUM_PH-1:0]  want_lo
);

    logic       code_ok;
    logic [1:0] fwd_src;
    logic [1:0] fwd_snk;
    logic [NUM_PH-1:0] src_vec;
    logic [NUM_PH-1:0] snk_vec;

    // six-step table, forward direction
    always_comb begin
        code_ok = 1'b1;
        fwd_src = 2'd0;
        fwd_snk = 2'd0;
        unique case (hall)
            3'b001: begin fwd_src = 2'd0; fwd_snk = 2'd1; end
            3'b011: begin fwd_src = 2'd0; fwd_snk = 2'd2; end
            3'b010: begin fwd_src = 2'd1; fwd_snk = 2'd2; end
            3'b110: begin fwd_src = 2'd1; fwd_snk = 2'd0; end
            3'b100: begin fwd_src = 2'd2; fwd_snk = 2'd0; end
            3'b101: begin fwd_src = 2'd2; fwd_snk = 2'd1; end
            default: code_ok = 1'b0;
        endcase
    end

    // reverse swaps source and sink
    always_comb begin
        if (dir_rev) begin
            src_vec = NUM_PH'(1) << fwd_snk;
            snk_vec = NUM_PH'(1) << fwd_src;
        end else begin
            src_vec = NUM_PH'(1) << fwd_src;
            snk_vec = NUM_PH'(1) << fwd_snk;
        end
    end

    // request per phase from the drive mode
    always_comb begin
        want_hi = '0;
        want_lo = '0;
        unique case (mode)
            MD_RUN: begin
                if (code_ok) begin
                    want_hi = pwm_on ? src_vec : '0;
                    want_lo = snk_vec | (pwm_on ? '0 : src_vec);
                end
            end
            MD_BRAKE: want_lo = '1;
            MD_COAST: ;
            default: ;
        endcase
    end

endmodule

// File: rtl/phase_gate_fsm.sv
module phase_gate_fsm
    import bldc_pkg::*;
#(
    parameter int DEAD_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic want_hi,
    input  logic want_lo,
    output logic hi_on,
    output logic lo_on
);

    localparam int CW = (DEAD_CYCLES < 2) ? 1 : $clog2(DEAD_CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(DEAD_CYCLES - 1);

    phase_st_e st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= PH_OFF;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // transitions
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            PH_OFF: begin
                if (want_hi)      st_d = PH_HIGH;
                else if (want_lo) st_d = PH_LOW;
            end
            PH_HIGH: begin
                if (!want_hi) begin
                    st_d  = PH_DEAD;
                    cnt_d = LOAD;
                end
            end
            PH_LOW: begin
                if (!want_lo) begin
                    st_d  = PH_DEAD;
                    cnt_d = LOAD;
                end
            end
            PH_DEAD: begin
                if (cnt_q == '0) begin
                    if (want_hi)      st_d = PH_HIGH;
                    else if (want_lo) st_d = PH_LOW;
                    else              st_d = PH_OFF;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: st_d = PH_OFF;
        endcase
    end

    // outputs
    always_comb begin
        hi_on = 1'b0;
        lo_on = 1'b0;
        unique case (st_q)
            PH_HIGH: hi_on = 1'b1;
            PH_LOW:  lo_on = 1'b1;
            PH_OFF, PH_DEAD: ;
            default: ;
        endcase
    end

endmodule

// File: rtl/bldc_commutator.sv
module bldc_commutator
    import bldc_pkg::*;
#(
    parameter int DEAD_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_PH-1:0] hall,
    input  logic              dir_rev,
    input  logic              start_n,
    input  logic              brake_sel_n,
    input  logic              pwm_on,
    input  logic              hs_kill,
    output logic [NUM_PH-1:0] gate_hi,
    output logic [NUM_PH-1:0] gate_lo,
    output logic              hall_bias
);

    drive_mode_e       mode;
    logic [NUM_PH-1:0] want_hi, want_lo;
    logic [NUM_PH-1:0] hi_raw;

    drive_mode_fsm u_mode (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_n     (start_n),
        .brake_sel_n (brake_sel_n),
        .mode        (mode)
    );

    hall_commutator u_comm (
        .mode    (mode),
        .hall    (hall),
        .dir_rev (dir_rev),
        .pwm_on  (pwm_on),
        .want_hi (want_hi),
        .want_lo (want_lo)
    );

    for (genvar p = 0; p < NUM_PH; p++) begin : g_phase
        phase_gate_fsm #(.DEAD_CYCLES(DEAD_CYCLES)) u_gate (
            .clk     (clk),
            .rst_n   (rst_n),
            .want_hi (want_hi[p]),
            .want_lo (want_lo[p]),
            .hi_on   (hi_raw[p]),
            .lo_on   (gate_lo[p])
        );
    end

    assign gate_hi   = hi_raw & ~{NUM_PH{hs_kill}};
    assign hall_bias = (mode == MD_RUN);

endmodule

// File: rtl/bldc_commutator_chk.sv
module bldc_commutator_chk #(
    parameter int DEAD_CYCLES = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] hall,
    input logic       start_n,
    input logic       hs_kill,
    input logic [2:0] gate_hi,
    input logic [2:0] gate_lo,
    input logic       hall_bias
);

    // R8
    no_shoot_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_hi & gate_lo) == 3'b000);

    for (genvar g = 0; g < 3; g++) begin : g_gap
        int unsigned since_hi, since_lo;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                since_hi <= DEAD_CYCLES;
                since_lo <= DEAD_CYCLES;
            end else begin
                if (gate_hi[g])                 since_hi <= 0;
                else if (since_hi < DEAD_CYCLES) since_hi <= since_hi + 1;
                if (gate_lo[g])                 since_lo <= 0;
                else if (since_lo < DEAD_CYCLES) since_lo <= since_lo + 1;
            end
        end

        // R8
        lo_dead_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(gate_lo[g]) |-> since_hi >= DEAD_CYCLES);

        // R8
        hi_dead_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(gate_hi[g]) |-> since_lo >= DEAD_CYCLES);
    end

    // R9
    hs_kill_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hs_kill |-> gate_hi == 3'b000);

    // R3
    invalid_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hall == 3'b000 || hall == 3'b111) |=> gate_hi == 3'b000);

    // R4
    bias_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start_n |=> hall_bias);

    // R4
    bias_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_n |=> !hall_bias);

    // R5
    stopped_no_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_n && $past(start_n)) |=> gate_hi == 3'b000);

endmodule

bind bldc_commutator bldc_commutator_chk #(.DEAD_CYCLES(DEAD_CYCLES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hall      (hall),
    .start_n   (start_n),
    .hs_kill   (hs_kill),
    .gate_hi   (gate_hi),
    .gate_lo   (gate_lo),
    .hall_bias (hall_bias)
);

// File: tb/bldc_commutator_test.sv
module bldc_commutator_test;

    localparam int CLK_PERIOD = 10;
    localparam int DEAD       = 4;
    localparam int SETTLE     = DEAD + 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] hall = 3'b000;
    logic       dir_rev = 1'b0;
    logic       start_n = 1'b1;
    logic       brake_sel_n = 1'b1;
    logic       pwm_on = 1'b1;
    logic       hs_kill = 1'b0;
    logic [2:0] gate_hi, gate_lo;
    logic       hall_bias;

    int n_cmp = 0;
    int n_bad = 0;

    typedef struct {
        logic [6:0] exp;
        string      tag;
    } item_t;
    item_t sb_q[$];

    bldc_commutator #(.DEAD_CYCLES(DEAD)) uut (
        .clk(clk), .rst_n(rst_n), .hall(hall), .dir_rev(dir_rev),
        .start_n(start_n), .brake_sel_n(brake_sel_n), .pwm_on(pwm_on),
        .hs_kill(hs_kill), .gate_hi(gate_hi), .gate_lo(gate_lo),
        .hall_bias(hall_bias)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // expected {bias, lo[2:0], hi[2:0]} from the requirements
    function automatic logic [6:0] model(logic [2:0] h, logic rev, logic st_n,
                                         logic brk_n, logic pw, logic kl);
        int src = -1;
        int snk = 0;
        int tmp;
        logic [2:0] sv, kv, hi, lo;
        if (st_n) return {1'b0, (brk_n ? 3'b000 : 3'b111), 3'b000};
        case (h)
            3'b001: begin src = 0; snk = 1; end
            3'b011: begin src = 0; snk = 2; end
            3'b010: begin src = 1; snk = 2; end
            3'b110: begin src = 1; snk = 0; end
            3'b100: begin src = 2; snk = 0; end
            3'b101: begin src = 2; snk = 1; end
            default: src = -1;
        endcase
        if (src < 0) return {1'b1, 6'b000000};
        if (rev) begin tmp = src; src = snk; snk = tmp; end
        sv = 3'b001 << src;
        kv = 3'b001 << snk;
        hi = (pw && !kl) ? sv : 3'b000;
        lo = kv | (pw ? 3'b000 : sv);
        return {1'b1, lo, hi};
    endfunction

    task automatic report(input logic [6:0] got, input logic [6:0] exp, input string tag);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    // monitor: pops expected items and compares against the ports
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            report({hall_bias, gate_lo, gate_hi}, it.exp, it.tag);
        end
    end

    // driver: apply stimulus, wait to settle, push expected item
    task automatic apply(input logic [2:0] h, input logic rev, input logic st_n,
                         input logic brk_n, input logic pw, input logic kl,
                         input string tag);
        item_t it;
        @(negedge clk);
        hall = h; dir_rev = rev; start_n = st_n;
        brake_sel_n = brk_n; pwm_on = pw; hs_kill = kl;
        repeat (SETTLE) @(negedge clk);
        it.exp = model(h, rev, st_n, brk_n, pw, kl);
        it.tag = tag;
        sb_q.push_back(it);
        while (sb_q.size() != 0) @(posedge clk);
    endtask

    // toggle PWM on phase 0 (source) and count clocks with both sides off
    task automatic gap_check(input logic new_pwm, input string tag);
        int gap = 0;
        @(negedge clk);
        pwm_on = new_pwm;
        for (int i = 0; i < 3 * DEAD + 6; i++) begin
            @(negedge clk);
            if (gate_hi[0] || gate_lo[0]) break;
            gap++;
        end
        report(7'(gap), 7'(DEAD), tag);
        report({6'b0, (new_pwm ? gate_hi[0] : gate_lo[0])}, 7'd1, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        report({hall_bias, gate_lo, gate_hi}, 7'b0, "R10 reset");
        rst_n = 1'b1;

        apply(3'b001, 0, 1, 1, 1, 0, "R5 free run stop");
        apply(3'b001, 0, 1, 0, 1, 0, "R6 short brake");
        apply(3'b010, 0, 1, 1, 1, 0, "R5 brake to free");

        // R1 forward table, R4 bias on in run
        apply(3'b001, 0, 0, 1, 1, 0, "R4 run bias R1 001");
        apply(3'b011, 0, 0, 1, 1, 0, "R1 011");
        apply(3'b010, 0, 0, 1, 1, 0, "R1 010");
        apply(3'b110, 0, 0, 1, 1, 0, "R1 110");
        apply(3'b100, 0, 0, 1, 1, 0, "R1 100");
        apply(3'b101, 0, 0, 1, 1, 0, "R1 101");

        // R2 reverse
        apply(3'b101, 1, 0, 1, 1, 0, "R2 101");
        apply(3'b100, 1, 0, 1, 1, 0, "R2 100");
        apply(3'b110, 1, 0, 1, 1, 0, "R2 110");
        apply(3'b010, 1, 0, 1, 1, 0, "R2 010");
        apply(3'b011, 1, 0, 1, 1, 0, "R2 011");
        apply(3'b001, 1, 0, 1, 1, 0, "R2 001");

        // R3 invalid codes
        apply(3'b000, 0, 0, 1, 1, 0, "R3 000");
        apply(3'b111, 1, 0, 1, 0, 0, "R3 111");

        // R7 synchronous rectification
        apply(3'b011, 0, 0, 1, 0, 0, "R7 fwd 011");
        apply(3'b110, 1, 0, 1, 0, 0, "R7 rev 110");

        // R9 high-side kill
        apply(3'b010, 0, 0, 1, 1, 1, "R9 kill pwm1");
        apply(3'b010, 0, 0, 1, 0, 1, "R9 kill pwm0");
        apply(3'b010, 0, 0, 1, 1, 0, "R9 release");

        // R8 dead time both directions on phase 0
        apply(3'b001, 0, 0, 1, 1, 0, "R8 setup");
        gap_check(1'b0, "R8 high to low gap");
        gap_check(1'b1, "R8 low to high gap");

        // stop from run, both stop modes
        apply(3'b001, 0, 1, 0, 1, 0, "R6 run to brake");
        apply(3'b001, 0, 1, 1, 1, 0, "R4 R5 stop bias off");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule